// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit linear address into a physical address. It reads a chain of translation tables held in memory, one table per level. A mode pin picks four-level or five-level translation. The top table's base comes from a root input. At each level a 9-bit slice of the linear address selects one 64-bit entry. That entry either points to the next table or maps a page.

A one-cycle start pulse launches a walk. Before any memory traffic, the address is tested for proper sign extension above its highest meaningful bit. Entries are fetched through a read port that allows one read in flight at a time. The request side is a valid/ready handshake: once the walker raises the request valid, it holds the valid and the address unchanged until it sees ready. The response side has a valid and no ready. The walker always accepts a response in the cycle it arrives, so the memory must return exactly one response per accepted request.

A one-cycle done pulse reports the result: the physical address, the page size, a fault code and the faulting level. These result outputs hold their values until the next done.

Top module: `xlat_walker`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `mem_req_valid_o` are low until a start is accepted.
- R2: An address is canonical when bits 63..47 are all equal (four-level mode, `mode5_i`=0) or bits 63..56 are all equal (five-level mode, `mode5_i`=1). For a non-canonical address, `done_o` rises one cycle after the start is sampled, with `fault_o`=1 and `fault_lvl_o`=0, and no memory request is issued.
- R3: A walk begins at level 4 (four-level mode) or at level 5 (five-level mode) and descends one level per read. The read address for level L is table_base + 8 × va[12+9(L−1)+8 : 12+9(L−1)]. The first table_base is `root_i` with its low 12 bits cleared.
- R4: A present, non-leaf entry supplies the next table base from its bits 51:12.
- R5: An entry read at level 1 with bit 0 set ends the walk with `psize_o`=0 (4 KiB). `paddr_o` is entry[51:12] followed by va[11:0].
- R6: An entry read at level 2 with bits 0 and 7 set ends the walk with `psize_o`=1 (2 MiB). `paddr_o` is entry[51:21] followed by va[20:0]. Entry bits 20:12 are discarded.
- R7: An entry read at level 3 with bits 0 and 7 set ends the walk with `psize_o`=2 (1 GiB). `paddr_o` is entry[51:30] followed by va[29:0].
- R8: Bit 7 has no effect on entries read at levels 5, 4 and 1. The walk continues, or it ends as a 4 KiB page at level 1.
- R9: An entry with bit 0 clear ends the walk with `fault_o`=2 and `fault_lvl_o` set to the level of that entry (1 to 5). No further read is made.
- R10: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the valid stays high and `mem_req_addr_o` stays stable. Only one read is outstanding at a time, and every request address is 8-byte aligned.
- R11: A start that arrives while `busy_o` is high is ignored. The running walk completes with its own result, and no extra done follows.
- R12: `done_o` is high for exactly one cycle. `paddr_o`, `psize_o`, `fault_o` and `fault_lvl_o` hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a walk |
| mode5_i | input | 1 | 1 = five-level, 0 = four-level translation |
| vaddr_i | input | 64 | Linear address to translate |
| root_i | input | 52 | Physical base of the top table (4 KiB aligned) |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 52 | Physical address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| paddr_o | output | 52 | Translated physical address |
| psize_o | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| fault_o | output | 2 | 0 = none, 1 = non-canonical, 2 = not present |
| fault_lvl_o | output | 3 | Level of the not-present entry |

## Verification
Two functions can land on the same edge. One is the large-page decision on an entry that also has its present bit clear. The other is a fresh start pulse that arrives while the walker is back-pressured or finishing. The bench covers the first case by handing back a directory entry with the size bit set and the present bit clear, and expects the not-present fault at level 2 instead of a 2 MiB mapping. It covers the second by pulsing start, with a different address and mode, during a stalled walk, and expects the read trace, the result and the done count to match the first walk alone.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } walk_st_e;

  localparam logic [1:0] PG_4K = 2'd0;
  localparam logic [1:0] PG_2M = 2'd1;
  localparam logic [1:0] PG_1G = 2'd2;

  localparam logic [1:0] FLT_NONE  = 2'd0;
  localparam logic [1:0] FLT_CANON = 2'd1;
  localparam logic [1:0] FLT_NP    = 2'd2;

  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_LARGE   = 7;
endpackage

// File: rtl/xlat_canon.sv
module xlat_canon #(
  parameter int unsigned VA_W      = 64,
  parameter int unsigned MSB_SHORT = 47,
  parameter int unsigned MSB_LONG  = 56
) (
  input  logic [VA_W-1:MSB_SHORT] va_hi,
  input  logic                    long_mode,
  output logic                    canon_ok
);
  localparam int unsigned SHORT_W = VA_W - MSB_SHORT;
  localparam int unsigned LONG_W  = VA_W - MSB_LONG;

  logic [SHORT_W-1:0] top_short;
  logic [LONG_W-1:0]  top_long;
  logic               ok_short;
  logic               ok_long;

  assign top_short = va_hi[VA_W-1:MSB_SHORT];
  assign top_long  = va_hi[VA_W-1:MSB_LONG];
  assign ok_short  = (&top_short) | ~(|top_short);
  assign ok_long   = (&top_long) | ~(|top_long);
  assign canon_ok  = long_mode ? ok_long : ok_short;
endmodule

// File: rtl/xlat_idx_sel.sv
module xlat_idx_sel #(
  parameter int unsigned PA_W  = 52,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned ENT_B = 8,
  parameter int unsigned N_LVL = 5,
  parameter int unsigned LVL_W = 3
) (
  input  logic [IDX_W*N_LVL-1:0] va_idx,
  input  logic [LVL_W-1:0]       level,
  input  logic [PA_W-OFF_W-1:0]  tbl_base,
  output logic [PA_W-1:0]        ent_addr
);
  localparam int unsigned ENT_SH = $clog2(ENT_B);

  logic [IDX_W-1:0] idx_arr [N_LVL];
  logic [IDX_W-1:0] idx_sel;

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    assign idx_arr[g] = va_idx[IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (level == LVL_W'(i + 1)) idx_sel = idx_arr[i];
    end
  end

  assign ent_addr = {tbl_base, {OFF_W{1'b0}}} + (PA_W'(idx_sel) << ENT_SH);
endmodule

// File: rtl/xlat_pa_merge.sv
module xlat_pa_merge #(
  parameter int unsigned PA_W  = 52,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned OFF_W = 12
) (
  input  logic [PA_W-1:0] frame,
  input  logic [PA_W-1:0] va_lo,
  input  logic [1:0]      size,
  output logic [PA_W-1:0] pa
);
  import xlat_pkg::*;

  localparam int unsigned OFF_2M = OFF_W + IDX_W;
  localparam int unsigned OFF_1G = OFF_W + 2 * IDX_W;

  logic [PA_W-1:0] keep_lo;

  always_comb begin
    case (size)
      PG_2M:   keep_lo = (PA_W'(1) << OFF_2M) - PA_W'(1);
      PG_1G:   keep_lo = (PA_W'(1) << OFF_1G) - PA_W'(1);
      default: keep_lo = (PA_W'(1) << OFF_W) - PA_W'(1);
    endcase
  end

  assign pa = (frame & ~keep_lo) | (va_lo & keep_lo);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W      = 64,
  parameter int unsigned PA_W      = 52,
  parameter int unsigned ENT_W     = 64,
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned N_LVL     = 5,
  parameter int unsigned LVL_W     = 3,
  parameter int unsigned MSB_SHORT = 47,
  parameter int unsigned MSB_LONG  = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode5_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PA_W-1:0]  root_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [ENT_W-1:0] mem_rsp_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [1:0]       psize_o,
  output logic [1:0]       fault_o,
  output logic [LVL_W-1:0] fault_lvl_o
);
  localparam int unsigned FRM_W   = PA_W - OFF_W;
  localparam int unsigned IDX_TOP = OFF_W + IDX_W * N_LVL;
  localparam logic [LVL_W-1:0] LV_TOP_LONG  = LVL_W'(N_LVL);
  localparam logic [LVL_W-1:0] LV_TOP_SHORT = LVL_W'(N_LVL - 1);
  localparam logic [LVL_W-1:0] LV_1G = LVL_W'(3);
  localparam logic [LVL_W-1:0] LV_2M = LVL_W'(2);
  localparam logic [LVL_W-1:0] LV_PT = LVL_W'(1);

  walk_st_e         st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [FRM_W-1:0] base_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       psz_q;
  logic [1:0]       flt_q;
  logic [LVL_W-1:0] flvl_q;

  logic             canon_ok;
  logic [PA_W-1:0]  ent_addr;
  logic [PA_W-1:0]  leaf_pa;
  logic             ent_present;
  logic             ent_large;
  logic             leaf_1g;
  logic             leaf_2m;
  logic             is_leaf;
  logic [1:0]       leaf_size;
  logic             unused_bits;

  xlat_canon #(
    .VA_W(VA_W), .MSB_SHORT(MSB_SHORT), .MSB_LONG(MSB_LONG)
  ) u_canon (
    .va_hi     (vaddr_i[VA_W-1:MSB_SHORT]),
    .long_mode (mode5_i),
    .canon_ok  (canon_ok)
  );

  xlat_idx_sel #(
    .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_B(ENT_W / 8),
    .N_LVL(N_LVL), .LVL_W(LVL_W)
  ) u_idx (
    .va_idx   (va_q[IDX_TOP-1:OFF_W]),
    .level    (lvl_q),
    .tbl_base (base_q),
    .ent_addr (ent_addr)
  );

  assign ent_present = mem_rsp_data_i[BIT_PRESENT];
  assign ent_large   = mem_rsp_data_i[BIT_LARGE];
  assign leaf_1g     = (lvl_q == LV_1G) && ent_large;
  assign leaf_2m     = (lvl_q == LV_2M) && ent_large;
  assign is_leaf     = (lvl_q == LV_PT) || leaf_1g || leaf_2m;
  assign leaf_size   = leaf_1g ? PG_1G : (leaf_2m ? PG_2M : PG_4K);

  xlat_pa_merge #(
    .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_merge (
    .frame (mem_rsp_data_i[PA_W-1:0]),
    .va_lo (va_q[PA_W-1:0]),
    .size  (leaf_size),
    .pa    (leaf_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      base_q <= '0;
      va_q   <= '0;
      pa_q   <= '0;
      psz_q  <= PG_4K;
      flt_q  <= FLT_NONE;
      flvl_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            va_q <= vaddr_i;
            if (!canon_ok) begin
              pa_q   <= '0;
              psz_q  <= PG_4K;
              flt_q  <= FLT_CANON;
              flvl_q <= '0;
              st_q   <= ST_FIN;
            end else begin
              lvl_q  <= mode5_i ? LV_TOP_LONG : LV_TOP_SHORT;
              base_q <= root_i[PA_W-1:OFF_W];
              st_q   <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready_i) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            if (!ent_present) begin
              pa_q   <= '0;
              psz_q  <= PG_4K;
              flt_q  <= FLT_NP;
              flvl_q <= lvl_q;
              st_q   <= ST_FIN;
            end else if (is_leaf) begin
              pa_q   <= leaf_pa;
              psz_q  <= leaf_size;
              flt_q  <= FLT_NONE;
              flvl_q <= '0;
              st_q   <= ST_FIN;
            end else begin
              base_q <= mem_rsp_data_i[PA_W-1:OFF_W];
              lvl_q  <= lvl_q - LVL_W'(1);
              st_q   <= ST_REQ;
            end
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (st_q == ST_REQ);
  assign mem_req_addr_o  = ent_addr;
  assign busy_o          = (st_q != ST_IDLE);
  assign done_o          = (st_q == ST_FIN);
  assign paddr_o         = pa_q;
  assign psize_o         = psz_q;
  assign fault_o         = flt_q;
  assign fault_lvl_o     = flvl_q;

  assign unused_bits = ^{mem_rsp_data_i[ENT_W-1:PA_W], root_i[OFF_W-1:0],
                         va_q[VA_W-1:IDX_TOP]};
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int unsigned VA_W      = 64,
  parameter int unsigned PA_W      = 52,
  parameter int unsigned LVL_W     = 3,
  parameter int unsigned N_LVL     = 5,
  parameter int unsigned MSB_SHORT = 47,
  parameter int unsigned MSB_LONG  = 56
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    mode5_i,
  input logic [VA_W-1:MSB_SHORT] va_hi,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    mem_req_valid_o,
  input logic                    mem_req_ready_i,
  input logic [PA_W-1:0]         mem_req_addr_o,
  input logic [1:0]              fault_o,
  input logic [LVL_W-1:0]        fault_lvl_o
);
  logic sext_short;
  logic sext_long;
  logic sext_ok;

  assign sext_short = (va_hi == '1) || (va_hi == '0);
  assign sext_long  = (va_hi[VA_W-1:MSB_LONG] == '1) || (va_hi[VA_W-1:MSB_LONG] == '0);
  assign sext_ok    = mode5_i ? sext_long : sext_short;

  p_canon_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !sext_ok) |=> (done_o && fault_o == 2'd1 && !mem_req_valid_o));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_req_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000));

  p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  p_req_in_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> busy_o);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_np_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o == 2'd2) |-> (fault_lvl_o >= LVL_W'(1) && fault_lvl_o <= LVL_W'(N_LVL)));
endmodule

bind xlat_walker xlat_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W), .N_LVL(N_LVL),
  .MSB_SHORT(MSB_SHORT), .MSB_LONG(MSB_LONG)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .mode5_i         (mode5_i),
  .va_hi           (vaddr_i[VA_W-1:MSB_SHORT]),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .fault_o         (fault_o),
  .fault_lvl_o     (fault_lvl_o)
);

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mode5_i = 1'b0;
  logic [63:0] vaddr_i = '0;
  logic [51:0] root_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [51:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        busy_o, done_o;
  logic [51:0] paddr_o;
  logic [1:0]  psize_o, fault_o;
  logic [2:0]  fault_lvl_o;

  always #2 clk = ~clk;

  xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode5_i(mode5_i),
    .vaddr_i(vaddr_i), .root_i(root_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .busy_o(busy_o), .done_o(done_o),
    .paddr_o(paddr_o), .psize_o(psize_o), .fault_o(fault_o),
    .fault_lvl_o(fault_lvl_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int stall = 0;
  int rd_n = 0;
  int n_exp = 0;
  logic [51:0] rd_addr [8];
  logic [51:0] exp_addr [8];
  logic [63:0] mem [logic [51:0]];

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // memory model: request handshake, then a response two cycles later
  initial begin
    logic [51:0] a;
    forever begin
      @(negedge clk);
      mem_req_ready_i = 1'b0;
      mem_rsp_valid_i = 1'b0;
      if (mem_req_valid_o) begin
        a = mem_req_addr_o;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(mem_req_valid_o && mem_req_addr_o == a, "R10 request held under stall",
              {11'h0, mem_req_valid_o, mem_req_addr_o}, {12'h001, a});
        end
        mem_req_ready_i = 1'b1;
        if (rd_n < 8) rd_addr[rd_n] = a;
        rd_n++;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        chk(!mem_req_valid_o, "R10 single outstanding read", 64'(mem_req_valid_o), 64'h0);
        @(negedge clk);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem.exists(a) ? mem[a] : 64'h0;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
      end
    end
  end

  function automatic logic [51:0] ent_at(input logic [51:0] base, input logic [63:0] va, input int lv);
    return {base[51:12], 12'h0} + 52'(va[12 + 9 * (lv - 1) +: 9]) * 52'd8;
  endfunction

  function automatic logic [51:0] nb(input int lv);
    return 52'h0080_0000 + 52'(lv) * 52'h1000;
  endfunction

  task automatic build(input bit m5, input logic [63:0] va, input logic [51:0] root,
                       input int stop, input logic [63:0] leaf, input bit top_ps);
    logic [51:0] b, a;
    mem.delete();
    b = root;
    n_exp = 0;
    for (int lv = (m5 ? 5 : 4); lv >= stop; lv--) begin
      a = ent_at(b, va, lv);
      exp_addr[n_exp] = a;
      n_exp++;
      if (lv == stop) mem[a] = leaf;
      else begin
        mem[a] = {12'h0, nb(lv - 1)} | 64'h1 | ((top_ps && lv >= 4) ? 64'h80 : 64'h0);
        b = nb(lv - 1);
      end
    end
  endtask

  task automatic do_walk(input bit m5, input logic [63:0] va, input logic [51:0] root, output int lat);
    @(negedge clk);
    rd_n = 0;
    start_i = 1'b1; mode5_i = m5; vaddr_i = va; root_i = root;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 500) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic chk_reads(input string tag);
    chk(rd_n == n_exp, {tag, " read count"}, 64'(rd_n), 64'(n_exp));
    for (int i = 0; i < n_exp && i < rd_n; i++)
      chk(rd_addr[i] == exp_addr[i], {tag, " read address"}, 64'(rd_addr[i]), 64'(exp_addr[i]));
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o && !mem_req_valid_o, "R1 idle after reset",
        {busy_o, done_o, mem_req_valid_o}, 64'h0);
  endtask

  task automatic t_4k_short;
    logic [63:0] va = 64'h0000_1234_5678_9ABC;
    logic [63:0] leaf = 64'h0000_000A_BCDE_F081;
    int lat;
    stall = 0;
    build(1'b0, va, 52'h1000, 1, leaf, 1'b1);
    do_walk(1'b0, va, 52'h1000, lat);
    chk(done_o, "R5 walk completes", 64'(done_o), 64'h1);
    chk_reads("R3 R4 R8 four-level");
    chk(paddr_o == {leaf[51:12], va[11:0]}, "R5 4K address", 64'(paddr_o), {12'h0, leaf[51:12], va[11:0]});
    chk(psize_o == 2'd0 && fault_o == 2'd0, "R5 R8 4K size, no fault", {psize_o, fault_o}, 64'h0);
  endtask

  task automatic t_4k_long_stall;
    logic [63:0] va = 64'hFF9A_BCDE_F012_3456;
    logic [63:0] leaf = 64'h0000_0001_2345_6001;
    int lat;
    stall = 3;
    build(1'b1, va, 52'h7_5000, 1, leaf, 1'b1);
    do_walk(1'b1, va, 52'h7_5000, lat);
    chk_reads("R3 R8 R10 five-level stalled");
    chk(paddr_o == {leaf[51:12], va[11:0]}, "R5 five-level 4K address", 64'(paddr_o),
        {12'h0, leaf[51:12], va[11:0]});
    stall = 0;
  endtask

  task automatic t_2m;
    logic [63:0] va = 64'hFFFF_8765_4321_0FED;
    logic [63:0] leaf = 64'h0000_0003_456A_B081;
    int lat;
    stall = 1;
    build(1'b0, va, 52'h2000, 2, leaf, 1'b0);
    do_walk(1'b0, va, 52'h2000, lat);
    chk_reads("R2 R6 2M walk");
    chk(paddr_o == {leaf[51:21], va[20:0]}, "R6 2M address", 64'(paddr_o), {12'h0, leaf[51:21], va[20:0]});
    chk(psize_o == 2'd1 && fault_o == 2'd0, "R6 2M size", {psize_o, fault_o}, 64'h4);
    stall = 0;
  endtask

  task automatic t_1g;
    logic [63:0] va = 64'h0012_3456_789A_BCDE;
    logic [63:0] leaf = 64'h0000_00C0_3FFF_F081;
    int lat;
    build(1'b1, va, 52'h3000, 3, leaf, 1'b1);
    do_walk(1'b1, va, 52'h3000, lat);
    chk_reads("R7 1G walk");
    chk(paddr_o == {leaf[51:30], va[29:0]}, "R7 1G address", 64'(paddr_o), {12'h0, leaf[51:30], va[29:0]});
    chk(psize_o == 2'd2 && fault_o == 2'd0, "R7 1G size", {psize_o, fault_o}, 64'h8);
  endtask

  task automatic t_noncanon;
    int lat;
    mem.delete();
    n_exp = 0;
    do_walk(1'b0, 64'h0000_8000_0000_0000, 52'h1000, lat);
    chk(lat == 0 && done_o, "R2 fault one cycle after start", 64'(lat), 64'h0);
    chk(fault_o == 2'd1 && fault_lvl_o == 3'd0, "R2 non-canonical code (4-level)", {fault_lvl_o, fault_o}, 64'h1);
    chk(rd_n == 0, "R2 no read for non-canonical", 64'(rd_n), 64'h0);
    do_walk(1'b1, 64'h0100_0000_0000_0000, 52'h1000, lat);
    chk(lat == 0 && fault_o == 2'd1 && rd_n == 0, "R2 non-canonical code (5-level)",
        {lat[7:0], fault_o, rd_n[3:0]}, 64'h010);
  endtask

  task automatic t_np;
    logic [63:0] va = 64'h00AB_CDEF_0123_4567;
    int lat;
    build(1'b1, va, 52'h4000, 5, 64'h0000_0000_0055_5080, 1'b0);
    do_walk(1'b1, va, 52'h4000, lat);
    chk_reads("R9 top-level not present");
    chk(fault_o == 2'd2 && fault_lvl_o == 3'd5, "R9 fault at level 5", {fault_lvl_o, fault_o}, {3'd5, 2'd2});
    va = 64'h0000_7123_4567_89AB;
    build(1'b0, va, 52'h5000, 2, 64'h0000_0000_0066_6080, 1'b0);
    do_walk(1'b0, va, 52'h5000, lat);
    chk_reads("R9 directory not present with size bit");
    chk(fault_o == 2'd2 && fault_lvl_o == 3'd2 && paddr_o == '0, "R9 fault at level 2",
        {paddr_o, fault_lvl_o, fault_o}, {52'h0, 3'd2, 2'd2});
  endtask

  task automatic t_busy_start;
    logic [63:0] va = 64'h0000_0246_8ACE_1357;
    logic [63:0] leaf = 64'h0000_0009_8765_4001;
    logic [51:0] held;
    int lat, dones;
    stall = 2;
    build(1'b0, va, 52'h6000, 1, leaf, 1'b0);
    @(negedge clk);
    rd_n = 0;
    start_i = 1'b1; mode5_i = 1'b0; vaddr_i = va; root_i = 52'h6000;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o, "R11 walker busy", 64'(busy_o), 64'h1);
    start_i = 1'b1; mode5_i = 1'b1; vaddr_i = 64'h0100_0000_0000_0000;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    chk_reads("R11 first walk unaffected");
    chk(fault_o == 2'd0 && paddr_o == {leaf[51:12], va[11:0]}, "R11 result of first walk",
        64'(paddr_o), {12'h0, leaf[51:12], va[11:0]});
    held = paddr_o;
    @(negedge clk);
    chk(!done_o, "R12 done lasts one cycle", 64'(done_o), 64'h0);
    dones = 0;
    repeat (6) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    chk(dones == 0 && !busy_o, "R11 no extra done", 64'(dones), 64'h0);
    chk(paddr_o == held && psize_o == 2'd0, "R12 result held", 64'(paddr_o), 64'(held));
    stall = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_4k_short();
    t_4k_long_stall();
    t_2m();
    t_1g();
    t_noncanon();
    t_np();
    t_busy_start();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule